// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block gives two ports, each running on its own clock, a way to hand a single word to each other outside any queue. It holds two one-word mailboxes: one carries a word from port A to port B, the other from port B to port A. The clocks may be unrelated or may be the same clock. The mailbox width is one parameter and is set to the data width of port B.

Each mailbox has a presence flag that both sides observe. The sender sees it as a busy indication on its own clock, and the receiver sees it as a ready indication on its own clock. A store by the sender raises the flag. A read by the receiver lowers it. Each change crosses to the other clock through a two-flop synchronizer that carries a toggle, so only single-bit state crosses the boundary. While the flag is up, the stored word is held stable and further stores are refused. The receiver can therefore read the data bus directly, with no handshake on the data itself. One active-low master reset, asserted asynchronously, clears both mailboxes and all flags.

Top module: `mbox_pair`

## Requirements
- R1: While rstN is low, aMailBusy, aMailReady, bMailBusy and bMailReady are all 0. After release they stay 0 until the first store.
- R2: When aWrEn is high at a clkA edge while aMailBusy is 0, the word on aWrData is stored and aMailBusy is 1 after that edge. Within 3 clkB cycles, bMailReady becomes 1 and bRdData shows that word.
- R3: The B-to-A mailbox behaves the same with the roles swapped. A store through bWrEn/bWrData raises bMailBusy on clkB, and the word then appears on aRdData with aMailReady on clkA.
- R4: A store attempted while the sender's busy flag is 1 is ignored. The word later delivered to the receiver is the earlier one, and the busy flag stays 1.
- R5: A receiver's ready flag stays 1, with the data unchanged, until that receiver reads. A read (bRdEn or aRdEn high at its clock edge while ready is 1) lowers ready after that edge.
- R6: After the receiver reads, the sender's busy flag falls within 4 sender clock cycles, and the sender may then store again.
- R7: A read asserted while ready is 0 has no effect. Ready stays 0 and the sender's busy flag stays 0.
- R8: The two mailboxes are independent. Traffic in both directions at once, on clocks of different periods, delivers every word in order with none lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | Port A clock |
| clkB | input | 1 | Port B clock |
| rstN | input | 1 | Master reset, active low, asynchronous assertion |
| aWrEn | input | 1 | Port A store request into the A-to-B mailbox |
| aWrData | input | DATA_W | Word stored by port A |
| aMailBusy | output | 1 | A-to-B mailbox still holds unread mail (clkA domain) |
| aRdEn | input | 1 | Port A read of the B-to-A mailbox |
| aRdData | output | DATA_W | Word held in the B-to-A mailbox |
| aMailReady | output | 1 | New mail waits for port A (clkA domain) |
| bWrEn | input | 1 | Port B store request into the B-to-A mailbox |
| bWrData | input | DATA_W | Word stored by port B |
| bMailBusy | output | 1 | B-to-A mailbox still holds unread mail (clkB domain) |
| bRdEn | input | 1 | Port B read of the A-to-B mailbox |
| bRdData | output | DATA_W | Word held in the A-to-B mailbox |
| bMailReady | output | 1 | New mail waits for port B (clkB domain) |

## Verification
A toggle that is wrong on either side breaks the agreement between busy and ready. The symptom is one of these: a busy flag that never falls, a ready flag that never rises or rises twice for one store, or a lost word. Each shows at the ports within a few cycles of the next store or read, as a stall or a data mismatch. An overwrite that is not blocked shows up as the junk word arriving at the receiver in place of the stored word. Flag timing is bounded in both clock domains, and data is compared on every delivery in both directions while both directions run concurrently.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;
  // strobes from one mailbox's handshake control to its storage
  typedef struct packed {
    logic load;   // accepted store, sender clock
    logic take;   // accepted read, receiver clock
  } mbStrobe_t;
endpackage

// File: rtl/mbox_sync.sv
`timescale 1ns/1ps
module mbox_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbox_ctrl.sv
`timescale 1ns/1ps
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       wrClk,
  input  logic       rdClk,
  input  logic       rstN,
  input  logic       wrReq,
  input  logic       rdReq,
  output mbStrobe_t  strobe,
  output logic       wrBusy,
  output logic       rdReady
);
  logic wrTog, rdTog;
  logic wrTogAtRd, rdTogAtWr;

  // sender toggles once per accepted store
  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN)            wrTog <= 1'b0;
    else if (strobe.load) wrTog <= ~wrTog;
  end

  // receiver toggles once per accepted read
  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)            rdTog <= 1'b0;
    else if (strobe.take) rdTog <= ~rdTog;
  end

  mbox_sync #(.STAGES(SYNC_STAGES)) u_toRd (
    .clk(rdClk), .rstN(rstN), .d(wrTog), .q(wrTogAtRd)
  );

  mbox_sync #(.STAGES(SYNC_STAGES)) u_toWr (
    .clk(wrClk), .rstN(rstN), .d(rdTog), .q(rdTogAtWr)
  );

  always_comb begin
    wrBusy      = wrTog ^ rdTogAtWr;
    rdReady     = wrTogAtRd ^ rdTog;
    strobe.load = wrReq & ~wrBusy;
    strobe.take = rdReq & rdReady;
  end
endmodule

// File: rtl/mbox_data.sv
`timescale 1ns/1ps
module mbox_data
  import mbox_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              wrClk,
  input  logic              rstN,
  input  mbStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] word;

  // only loads while the flag is down, so the receiver sees a stable word
  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN)            word <= '0;
    else if (strobe.load) word <= wrData;
  end

  assign rdData = word;
endmodule

// File: rtl/mbox_pair.sv
`timescale 1ns/1ps
module mbox_pair
  import mbox_pkg::*;
#(
  parameter int DATA_W      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clkA,
  input  logic              clkB,
  input  logic              rstN,
  input  logic              aWrEn,
  input  logic [DATA_W-1:0] aWrData,
  output logic              aMailBusy,
  input  logic              aRdEn,
  output logic [DATA_W-1:0] aRdData,
  output logic              aMailReady,
  input  logic              bWrEn,
  input  logic [DATA_W-1:0] bWrData,
  output logic              bMailBusy,
  input  logic              bRdEn,
  output logic [DATA_W-1:0] bRdData,
  output logic              bMailReady
);
  localparam int N_DIR = 2;  // 0: A to B, 1: B to A

  logic              srcClk  [N_DIR];
  logic              dstClk  [N_DIR];
  logic              wrReqV  [N_DIR];
  logic              rdReqV  [N_DIR];
  logic [DATA_W-1:0] wrDataV [N_DIR];
  logic [DATA_W-1:0] rdDataV [N_DIR];
  logic              busyV   [N_DIR];
  logic              readyV  [N_DIR];

  assign srcClk[0]  = clkA;
  assign dstClk[0]  = clkB;
  assign wrReqV[0]  = aWrEn;
  assign rdReqV[0]  = bRdEn;
  assign wrDataV[0] = aWrData;
  assign srcClk[1]  = clkB;
  assign dstClk[1]  = clkA;
  assign wrReqV[1]  = bWrEn;
  assign rdReqV[1]  = aRdEn;
  assign wrDataV[1] = bWrData;

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    mbStrobe_t strobe;

    mbox_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
      .wrClk  (srcClk[d]),
      .rdClk  (dstClk[d]),
      .rstN   (rstN),
      .wrReq  (wrReqV[d]),
      .rdReq  (rdReqV[d]),
      .strobe (strobe),
      .wrBusy (busyV[d]),
      .rdReady(readyV[d])
    );

    mbox_data #(.DATA_W(DATA_W)) u_data (
      .wrClk (srcClk[d]),
      .rstN  (rstN),
      .strobe(strobe),
      .wrData(wrDataV[d]),
      .rdData(rdDataV[d])
    );
  end

  assign aMailBusy  = busyV[0];
  assign bMailReady = readyV[0];
  assign bRdData    = rdDataV[0];
  assign bMailBusy  = busyV[1];
  assign aMailReady = readyV[1];
  assign aRdData    = rdDataV[1];
endmodule

// File: rtl/mbox_pair_chk.sv
`timescale 1ns/1ps
module mbox_pair_chk #(
  parameter int DATA_W = 36
) (
  input logic              clkA,
  input logic              clkB,
  input logic              rstN,
  input logic              aWrEn,
  input logic              aMailBusy,
  input logic              aRdEn,
  input logic [DATA_W-1:0] aRdData,
  input logic              aMailReady,
  input logic              bWrEn,
  input logic              bMailBusy,
  input logic              bRdEn,
  input logic [DATA_W-1:0] bRdData,
  input logic              bMailReady
);
  // R1
  always @(posedge clkA) begin
    if (!rstN) reset_flags_chk: assert (!aMailBusy && !aMailReady && !bMailBusy && !bMailReady);
  end

  // R2
  a_store_sets_busy_chk: assert property (@(posedge clkA) disable iff (!rstN)
    aWrEn && !aMailBusy |=> aMailBusy);
  // R3
  b_store_sets_busy_chk: assert property (@(posedge clkB) disable iff (!rstN)
    bWrEn && !bMailBusy |=> bMailBusy);
  // R4
  a_blocked_store_chk: assert property (@(posedge clkA) disable iff (!rstN)
    aWrEn && aMailBusy |=> $stable(bRdData));
  // R4
  b_blocked_store_chk: assert property (@(posedge clkB) disable iff (!rstN)
    bWrEn && bMailBusy |=> $stable(aRdData));
  // R5
  b_ready_hold_chk: assert property (@(posedge clkB) disable iff (!rstN)
    bMailReady && !bRdEn |=> bMailReady && $stable(bRdData));
  // R5
  a_ready_hold_chk: assert property (@(posedge clkA) disable iff (!rstN)
    aMailReady && !aRdEn |=> aMailReady && $stable(aRdData));
  // R5
  b_take_clears_chk: assert property (@(posedge clkB) disable iff (!rstN)
    bRdEn && bMailReady |=> !bMailReady);
  // R5
  a_take_clears_chk: assert property (@(posedge clkA) disable iff (!rstN)
    aRdEn && aMailReady |=> !aMailReady);
endmodule

bind mbox_pair mbox_pair_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/mbox_pair_bench.sv
`timescale 1ns/1ps
module mbox_pair_bench;
  localparam int CLK_A_PERIOD = 10;
  localparam int CLK_B_PERIOD = 14;
  localparam int DATA_W       = 36;
  localparam int MSGS         = 24;

  logic clkA = 1'b0, clkB = 1'b0, rstN = 1'b0;
  logic aWrEn = 1'b0, aRdEn = 1'b0, bWrEn = 1'b0, bRdEn = 1'b0;
  logic [DATA_W-1:0] aWrData = '0, bWrData = '0;
  logic [DATA_W-1:0] aRdData, bRdData;
  logic aMailBusy, aMailReady, bMailBusy, bMailReady;

  int nCmp = 0, nBad = 0;
  bit finished = 0;

  always #(CLK_A_PERIOD/2) clkA = ~clkA;
  always #(CLK_B_PERIOD/2) clkB = ~clkB;

  mbox_pair #(.DATA_W(DATA_W)) u_mbox_pair (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // expected word for message idx in direction dir (0: A to B, 1: B to A)
  function automatic logic [DATA_W-1:0] mkWord(input int dir, input int idx);
    logic [63:0] h;
    h = 64'h9E37_79B9_7F4A_7C15 * 64'(idx + 1);
    if (dir != 0) h = h ^ 64'hA5C3_5A3C_0F0F_F0F1;
    return h[DATA_W-1:0];
  endfunction

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  // port A stores a word; optionally tries a junk overwrite while busy
  task automatic sendA(input logic [DATA_W-1:0] w, input bit junk);
    @(negedge clkA);
    while (aMailBusy) @(negedge clkA);
    aWrData = w; aWrEn = 1'b1;
    @(negedge clkA);
    aWrEn = 1'b0;
    check(aMailBusy == 1'b1, "R2", "aMailBusy after store", 64'(aMailBusy), 64'd1);
    if (junk) begin
      aWrData = ~w; aWrEn = 1'b1;
      @(negedge clkA);
      aWrEn = 1'b0;
      check(aMailBusy == 1'b1, "R4", "aMailBusy after blocked store", 64'(aMailBusy), 64'd1);
    end
  endtask

  task automatic sendB(input logic [DATA_W-1:0] w, input bit junk);
    @(negedge clkB);
    while (bMailBusy) @(negedge clkB);
    bWrData = w; bWrEn = 1'b1;
    @(negedge clkB);
    bWrEn = 1'b0;
    check(bMailBusy == 1'b1, "R3", "bMailBusy after store", 64'(bMailBusy), 64'd1);
    if (junk) begin
      bWrData = ~w; bWrEn = 1'b1;
      @(negedge clkB);
      bWrEn = 1'b0;
      check(bMailBusy == 1'b1, "R4", "bMailBusy after blocked store", 64'(bMailBusy), 64'd1);
    end
  endtask

  // port B waits for mail, holds off for hold cycles, then reads
  task automatic recvB(input logic [DATA_W-1:0] exp, input int hold);
    @(negedge clkB);
    while (!bMailReady) @(negedge clkB);
    check(bRdData == exp, "R8", "bRdData delivered word", 64'(bRdData), 64'(exp));
    for (int i = 0; i < hold; i++) begin
      @(negedge clkB);
      check(bMailReady && bRdData == exp, "R5", "bMailReady held before read",
            64'(bRdData), 64'(exp));
    end
    bRdEn = 1'b1;
    @(negedge clkB);
    bRdEn = 1'b0;
    check(bMailReady == 1'b0, "R5", "bMailReady after read", 64'(bMailReady), 64'd0);
  endtask

  task automatic recvA(input logic [DATA_W-1:0] exp, input int hold);
    @(negedge clkA);
    while (!aMailReady) @(negedge clkA);
    check(aRdData == exp, "R8", "aRdData delivered word", 64'(aRdData), 64'(exp));
    for (int i = 0; i < hold; i++) begin
      @(negedge clkA);
      check(aMailReady && aRdData == exp, "R5", "aMailReady held before read",
            64'(aRdData), 64'(exp));
    end
    aRdEn = 1'b1;
    @(negedge clkA);
    aRdEn = 1'b0;
    check(aMailReady == 1'b0, "R5", "aMailReady after read", 64'(aMailReady), 64'd0);
  endtask

  initial begin
    #(CLK_B_PERIOD * 150000);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [DATA_W-1:0] w;
    int cnt;
    void'($urandom(32'd20250611));

    repeat (3) @(negedge clkB);
    // R1: flags low during reset
    check(!aMailBusy && !aMailReady && !bMailBusy && !bMailReady, "R1", "flags in reset",
          64'({aMailBusy, aMailReady, bMailBusy, bMailReady}), 64'd0);
    @(negedge clkA);
    rstN = 1'b1;
    repeat (2) @(negedge clkB);
    check(!aMailBusy && !aMailReady && !bMailBusy && !bMailReady, "R1", "flags after reset",
          64'({aMailBusy, aMailReady, bMailBusy, bMailReady}), 64'd0);

    // R7: reads with nothing present
    @(negedge clkB); bRdEn = 1'b1;
    @(negedge clkA); aRdEn = 1'b1;
    @(negedge clkA); aRdEn = 1'b0;
    @(negedge clkB); bRdEn = 1'b0;
    repeat (4) @(negedge clkA);
    check(!bMailReady && !aMailBusy && !aMailReady && !bMailBusy, "R7", "empty read no effect",
          64'({aMailBusy, aMailReady, bMailBusy, bMailReady}), 64'd0);

    // R2 and R6 directed latency, A to B
    w = 36'h8_0000_0001;
    @(negedge clkA);
    aWrData = w; aWrEn = 1'b1;
    @(negedge clkA);
    aWrEn = 1'b0;
    check(aMailBusy == 1'b1, "R2", "aMailBusy after store", 64'(aMailBusy), 64'd1);
    cnt = 0;
    @(negedge clkB);
    while (!bMailReady && cnt < 10) begin cnt++; @(negedge clkB); end
    check(cnt <= 3, "R2", "bMailReady latency in clkB cycles", 64'(cnt), 64'd3);
    check(bRdData == w, "R2", "bRdData", 64'(bRdData), 64'(w));
    bRdEn = 1'b1;
    @(negedge clkB);
    bRdEn = 1'b0;
    check(bMailReady == 1'b0, "R5", "bMailReady after read", 64'(bMailReady), 64'd0);
    cnt = 0;
    @(negedge clkA);
    while (aMailBusy && cnt < 10) begin cnt++; @(negedge clkA); end
    check(cnt <= 4, "R6", "aMailBusy release in clkA cycles", 64'(cnt), 64'd4);

    // R3 and R6 directed, B to A
    w = 36'hF_FFFF_FFFE;
    fork
      sendB(w, 1'b1);
      recvA(w, 2);
    join
    cnt = 0;
    @(negedge clkB);
    while (bMailBusy && cnt < 10) begin cnt++; @(negedge clkB); end
    check(cnt <= 4, "R6", "bMailBusy release in clkB cycles", 64'(cnt), 64'd4);
    check(aMailReady == 1'b0, "R3", "aMailReady after read", 64'(aMailReady), 64'd0);

    // R8: both directions at once, random spacing and blocked stores (R4)
    fork
      for (int i = 0; i < MSGS; i++) begin
        repeat ($urandom_range(0, 4)) @(negedge clkA);
        sendA(mkWord(0, i), 1'($urandom_range(0, 1)));
      end
      for (int i = 0; i < MSGS; i++) begin
        repeat ($urandom_range(0, 3)) @(negedge clkB);
        recvB(mkWord(0, i), $urandom_range(0, 3));
      end
      for (int i = 0; i < MSGS; i++) begin
        repeat ($urandom_range(0, 4)) @(negedge clkB);
        sendB(mkWord(1, i), 1'($urandom_range(0, 1)));
      end
      for (int i = 0; i < MSGS; i++) begin
        repeat ($urandom_range(0, 3)) @(negedge clkA);
        recvA(mkWord(1, i), $urandom_range(0, 3));
      end
    join

    repeat (8) @(negedge clkB);
    check(!aMailBusy && !aMailReady && !bMailBusy && !bMailReady, "R8", "idle after traffic",
          64'({aMailBusy, aMailReady, bMailBusy, bMailReady}), 64'd0);
    finishRun();
  end
endmodule